// File: doc/BRIEF.md
# APB Transfer Serialisation Monitor

This block sits beside one APB manager-to-slave link and only listens. Every clock it sorts the bus cycle into idle, setup or access. It uses two bits of history, whether the previous cycle was a setup and whether a transfer is open, to decide whether the new cycle is a legal successor. Four classes of protocol break are caught: a setup that is not followed by an access, a new setup that starts while an access is still waiting, a change of the transfer's address or write controls during its access cycles, and an enable strobe that appears with no select.

Alongside the checks it measures cost. A completed transfer reports its wait-state count N and its total length, which is always N + 2. Three running totals count finished transfers, wait cycles and selected (busy) cycles, so an environment can confirm that back-to-back traffic never overlaps. All outputs are registered and describe the cycle sampled at the previous rising edge.

Top module: `apb_serial_mon`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, phase_o is 0, err_flags_o is 0, err_pulse_o and done_o are 0, and every counter and per-transfer output is 0.
- R2: phase_o reports the previous sampled cycle: 0 when psel_i and penable_i are both low, 1 (setup) for psel_i high with penable_i low, 2 (access) for both high, and 3 for penable_i high with psel_i low.
- R3: A setup cycle followed by any cycle that is not an access sets err_flags_o bit 0 and pulses err_pulse_o with err_code_o = 0.
- R4: An access with pready_i low inside an open transfer, followed by a setup cycle, sets err_flags_o bit 1 and pulses err_pulse_o with err_code_o = 1.
- R5: In any access cycle of an open transfer, a paddr_i, pwrite_i or pwdata_i value that differs from the one seen in its setup cycle sets err_flags_o bit 2 and gives err_code_o = 2.
- R6: penable_i high with psel_i low sets err_flags_o bit 3 with err_code_o = 3. When several classes fire in one cycle, err_code_o carries the lowest code and every matching flag bit is set.
- R7: err_flags_o bits stay set until rst_ni goes low. err_pulse_o is high only in the cycle after a violating cycle.
- R8: xfer_cnt_o rises by one, and done_o pulses for one cycle, for each access with pready_i high that closes a transfer opened by a setup.
- R9: At each completion, last_wait_o holds N, the transfer's count of access cycles with pready_i low, and last_cost_o holds N + 2.
- R10: busy_cnt_o counts every cycle with psel_i high. wait_cnt_o counts every access cycle with pready_i low inside an open transfer. Four back-to-back zero-wait transfers add exactly 8 to busy_cnt_o.
- R11: The three running totals saturate at all ones instead of wrapping.
- R12: Unless busy_cnt_o is saturated, busy_cnt_o is never below twice xfer_cnt_o.
- R13: Dropping psel_i after an unfinished access ends the transfer with no error flag and no increment of xfer_cnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Observed slave select |
| penable_i | input | 1 | Observed enable strobe |
| pready_i | input | 1 | Observed slave ready |
| paddr_i | input | AW | Observed address |
| pwrite_i | input | 1 | Observed write/read direction |
| pwdata_i | input | DW | Observed write data |
| phase_o | output | 2 | Class of the last sampled cycle |
| err_flags_o | output | 4 | Sticky violation flags, one bit per class |
| err_pulse_o | output | 1 | One-cycle violation strobe |
| err_code_o | output | 2 | Class of the violation being strobed |
| done_o | output | 1 | One-cycle strobe on transfer completion |
| last_wait_o | output | CW | Wait cycles of the last completed transfer |
| last_cost_o | output | CW | Total cycles of the last completed transfer |
| xfer_cnt_o | output | CW | Completed transfers, saturating |
| wait_cnt_o | output | CW | Wait cycles inside transfers, saturating |
| busy_cnt_o | output | CW | Cycles with select high, saturating |

## Verification
The overlap property assumes that the bus enters an access only from a setup or from a continuing access. An access that starts straight out of idle is not tracked as an open transfer, so no overlap flag would follow it. The cost relation assumes wait counts stay far below the counter limit. The stimulus builds every access on a preceding setup, keeps waits between zero and three, and creates illegal patterns only in the four flagged classes, one directed case each, with a reset between cases.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
  localparam int unsigned NUM_ERR = 4;
  localparam int unsigned E_EARLY    = 0;
  localparam int unsigned E_OVERLAP  = 1;
  localparam int unsigned E_UNSTABLE = 2;
  localparam int unsigned E_STRAY_EN = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_STRAY  = 2'd3
  } ph_e;
endpackage

// File: rtl/apb_mon_sat_cnt.sv
module apb_mon_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/apb_mon_tracker.sv
module apb_mon_tracker
  import apb_mon_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pready_i,
  input  logic [AW-1:0]      paddr_i,
  input  logic               pwrite_i,
  input  logic [DW-1:0]      pwdata_i,
  output logic [NUM_ERR-1:0] viol_o,
  output logic               setup_o,
  output logic               wait_o,
  output logic               done_o,
  output ph_e                phase_o
);
  logic          open_q, prev_setup_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic          is_setup, is_access, changed;

  assign is_setup  = psel_i & ~penable_i;
  assign is_access = psel_i & penable_i;
  assign changed   = (paddr_i != addr_q) | (pwrite_i != wr_q) | (pwdata_i != wd_q);

  assign setup_o = is_setup;
  assign wait_o  = open_q & is_access & ~pready_i;
  assign done_o  = open_q & is_access & pready_i;

  always_comb begin
    viol_o             = '0;
    viol_o[E_EARLY]    = prev_setup_q & ~is_access;
    // open and not just out of setup: previous cycle was a waiting access
    viol_o[E_OVERLAP]  = open_q & ~prev_setup_q & is_setup;
    viol_o[E_UNSTABLE] = open_q & is_access & changed;
    viol_o[E_STRAY_EN] = penable_i & ~psel_i;
  end

  always_comb begin
    unique case ({psel_i, penable_i})
      2'b10:   phase_o = PH_SETUP;
      2'b11:   phase_o = PH_ACCESS;
      2'b01:   phase_o = PH_STRAY;
      default: phase_o = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q       <= 1'b0;
      prev_setup_q <= 1'b0;
      addr_q       <= '0;
      wr_q         <= 1'b0;
      wd_q         <= '0;
    end else begin
      open_q       <= is_setup | (open_q & is_access & ~pready_i);
      prev_setup_q <= is_setup;
      if (is_setup) begin
        addr_q <= paddr_i;
        wr_q   <= pwrite_i;
        wd_q   <= pwdata_i;
      end
    end
  end
endmodule

// File: rtl/apb_mon_stats.sv
module apb_mon_stats
  import apb_mon_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] viol_i,
  input  logic               setup_i,
  input  logic               wait_i,
  input  logic               done_i,
  input  logic               psel_i,
  output logic [NUM_ERR-1:0] err_flags_o,
  output logic               err_pulse_o,
  output logic [1:0]         err_code_o,
  output logic               done_o,
  output logic [CW-1:0]      last_wait_o,
  output logic [CW-1:0]      last_cost_o,
  output logic [CW-1:0]      xfer_cnt_o,
  output logic [CW-1:0]      wait_cnt_o,
  output logic [CW-1:0]      busy_cnt_o
);
  localparam int unsigned NTOT = 3;

  logic [NTOT-1:0] tot_inc;
  logic [CW-1:0]   tot_cnt [NTOT];
  logic [CW-1:0]   cur_cost_q, cur_wait_q;
  logic [1:0]      code_d;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign tot_inc = {psel_i, wait_i, done_i};

  for (genvar g = 0; g < NTOT; g++) begin : g_tot
    apb_mon_sat_cnt #(.W(CW)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (tot_inc[g]),
      .cnt_o (tot_cnt[g])
    );
  end

  assign xfer_cnt_o = tot_cnt[0];
  assign wait_cnt_o = tot_cnt[1];
  assign busy_cnt_o = tot_cnt[2];

  // lowest class wins when several fire together
  always_comb begin
    code_d = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (viol_i[i]) code_d = 2'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_flags_o <= '0;
      err_pulse_o <= 1'b0;
      err_code_o  <= '0;
      done_o      <= 1'b0;
      last_wait_o <= '0;
      last_cost_o <= '0;
      cur_cost_q  <= '0;
      cur_wait_q  <= '0;
    end else begin
      err_flags_o <= err_flags_o | viol_i;
      err_pulse_o <= |viol_i;
      if (|viol_i) err_code_o <= code_d;
      done_o      <= done_i;
      if (setup_i) begin
        cur_cost_q <= CW'(1);
        cur_wait_q <= '0;
      end else if (wait_i) begin
        cur_cost_q <= sat_inc(cur_cost_q);
        cur_wait_q <= sat_inc(cur_wait_q);
      end
      if (done_i) begin
        last_cost_o <= sat_inc(cur_cost_q);
        last_wait_o <= cur_wait_q;
      end
    end
  end
endmodule

// File: rtl/apb_serial_mon.sv
module apb_serial_mon
  import apb_mon_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pready_i,
  input  logic [AW-1:0] paddr_i,
  input  logic          pwrite_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [1:0]    phase_o,
  output logic [3:0]    err_flags_o,
  output logic          err_pulse_o,
  output logic [1:0]    err_code_o,
  output logic          done_o,
  output logic [CW-1:0] last_wait_o,
  output logic [CW-1:0] last_cost_o,
  output logic [CW-1:0] xfer_cnt_o,
  output logic [CW-1:0] wait_cnt_o,
  output logic [CW-1:0] busy_cnt_o
);
  logic [NUM_ERR-1:0] viol;
  logic               setup_c, wait_c, done_c;
  ph_e                phase_d, phase_q;

  apb_mon_tracker #(.AW(AW), .DW(DW)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pready_i (pready_i),
    .paddr_i  (paddr_i),
    .pwrite_i (pwrite_i),
    .pwdata_i (pwdata_i),
    .viol_o   (viol),
    .setup_o  (setup_c),
    .wait_o   (wait_c),
    .done_o   (done_c),
    .phase_o  (phase_d)
  );

  apb_mon_stats #(.CW(CW)) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .viol_i     (viol),
    .setup_i    (setup_c),
    .wait_i     (wait_c),
    .done_i     (done_c),
    .psel_i     (psel_i),
    .err_flags_o(err_flags_o),
    .err_pulse_o(err_pulse_o),
    .err_code_o (err_code_o),
    .done_o     (done_o),
    .last_wait_o(last_wait_o),
    .last_cost_o(last_cost_o),
    .xfer_cnt_o (xfer_cnt_o),
    .wait_cnt_o (wait_cnt_o),
    .busy_cnt_o (busy_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/apb_serial_mon_chk.sv
module apb_serial_mon_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          psel_i,
  input logic          penable_i,
  input logic          pready_i,
  input logic [3:0]    err_flags_o,
  input logic          err_pulse_o,
  input logic [1:0]    err_code_o,
  input logic          done_o,
  input logic [CW-1:0] last_wait_o,
  input logic [CW-1:0] last_cost_o,
  input logic [CW-1:0] xfer_cnt_o,
  input logic [CW-1:0] busy_cnt_o
);
  assert_busy_floor_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, busy_cnt_o} >= {xfer_cnt_o, 1'b0}) || (&busy_cnt_o));

  assert_flags_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flags_o & $past(err_flags_o)) == $past(err_flags_o));

  assert_pulse_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> err_flags_o[err_code_o]);

  assert_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && !pready_i) ##1 (psel_i && !penable_i) |=> err_flags_o[1]);

  assert_cost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (({1'b0, last_cost_o} == {1'b0, last_wait_o} + 2) || (&last_cost_o)));

  assert_xfer_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_cnt_o - $past(xfer_cnt_o)) <= CW'(1));

  assert_busy_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt_o != $past(busy_cnt_o)) |-> $past(psel_i));
endmodule

bind apb_serial_mon apb_serial_mon_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pready_i   (pready_i),
  .err_flags_o(err_flags_o),
  .err_pulse_o(err_pulse_o),
  .err_code_o (err_code_o),
  .done_o     (done_o),
  .last_wait_o(last_wait_o),
  .last_cost_o(last_cost_o),
  .xfer_cnt_o (xfer_cnt_o),
  .busy_cnt_o (busy_cnt_o)
);

// File: tb/apb_serial_mon_test.sv
`timescale 1ns/1ps
module apb_serial_mon_test;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 32;
  localparam int unsigned SW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          psel_i = 1'b0, penable_i = 1'b0, pready_i = 1'b0, pwrite_i = 1'b0;
  logic [AW-1:0] paddr_i = '0;
  logic [DW-1:0] pwdata_i = '0;

  logic [1:0]    phase_o, err_code_o;
  logic [3:0]    err_flags_o;
  logic          err_pulse_o, done_o;
  logic [CW-1:0] last_wait_o, last_cost_o, xfer_cnt_o, wait_cnt_o, busy_cnt_o;

  logic [1:0]    s_phase, s_code;
  logic [3:0]    s_flags;
  logic          s_pulse, s_done;
  logic [SW-1:0] s_lw, s_lc, s_xfer, s_wait, s_busy;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  apb_serial_mon #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pready_i(pready_i), .paddr_i(paddr_i), .pwrite_i(pwrite_i), .pwdata_i(pwdata_i),
    .phase_o(phase_o), .err_flags_o(err_flags_o), .err_pulse_o(err_pulse_o),
    .err_code_o(err_code_o), .done_o(done_o), .last_wait_o(last_wait_o),
    .last_cost_o(last_cost_o), .xfer_cnt_o(xfer_cnt_o), .wait_cnt_o(wait_cnt_o),
    .busy_cnt_o(busy_cnt_o)
  );

  apb_serial_mon #(.AW(AW), .DW(DW), .CW(SW)) uut_sat (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pready_i(pready_i), .paddr_i(paddr_i), .pwrite_i(pwrite_i), .pwdata_i(pwdata_i),
    .phase_o(s_phase), .err_flags_o(s_flags), .err_pulse_o(s_pulse),
    .err_code_o(s_code), .done_o(s_done), .last_wait_o(s_lw),
    .last_cost_o(s_lc), .xfer_cnt_o(s_xfer), .wait_cnt_o(s_wait),
    .busy_cnt_o(s_busy)
  );

  function automatic int unsigned cost_of(input int unsigned waits);
    return waits + 2;
  endfunction

  function automatic int unsigned sat_of(input int unsigned v, input int unsigned w);
    int unsigned lim = (1 << w) - 1;
    return (v > lim) ? lim : v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one bus cycle, return just after the sampling edge
  task automatic cyc(input logic s, input logic e, input logic r,
                     input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    psel_i = s; penable_i = e; pready_i = r; paddr_i = a; pwrite_i = w; pwdata_i = d;
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic do_reset();
    psel_i = 0; penable_i = 0; pready_i = 0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                      input int unsigned waits);
    cyc(1, 0, 0, a, w, d);
    for (int i = 0; i < int'(waits); i++) cyc(1, 1, 0, a, w, d);
    cyc(1, 1, 1, a, w, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] b0, x0, w0;
    int unsigned eb, ex, ew;
    void'($urandom(32'h1f2e3d4c));

    // R1 reset state, during and just after reset
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 flags in reset", {60'd0, err_flags_o}, 64'd0);
    check("R1 busy in reset", busy_cnt_o, 0);
    rst_ni = 1'b1;
    idle(1);
    check("R1 phase", phase_o, 0);
    check("R1 xfer", xfer_cnt_o, 0);
    check("R1 pulse/done", {err_pulse_o, done_o}, 0);
    check("R1 last_cost", last_cost_o, 0);

    // R2 phase encoding, R10 four back-to-back zero-wait transfers
    cyc(1, 0, 0, 32'h10, 1, 32'hA);
    check("R2 setup phase", phase_o, 1);
    cyc(1, 1, 1, 32'h10, 1, 32'hA);
    check("R2 access phase", phase_o, 2);
    check("R8 done pulse", done_o, 1);
    for (int i = 0; i < 3; i++) xfer(32'h20 + i, 0, 0, 0);
    idle(1);
    check("R2 idle phase", phase_o, 0);
    check("R10 busy for four zero-wait", busy_cnt_o, 8);
    check("R8 xfer count", xfer_cnt_o, 4);
    check("R8 done clears", done_o, 0);

    // R9 three wait states
    xfer(32'h44, 1, 32'h55, 3);
    check("R9 last_wait", last_wait_o, 3);
    check("R9 last_cost", last_cost_o, cost_of(3));
    check("R10 wait total", wait_cnt_o, 3);
    check("R10 busy total", busy_cnt_o, 8 + cost_of(3));

    // R13 abort by dropping select
    cyc(1, 0, 0, 32'h60, 0, 0);
    cyc(1, 1, 0, 32'h60, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    check("R13 no flag", err_flags_o, 0);
    check("R13 no count", xfer_cnt_o, 5);
    check("R13 busy", busy_cnt_o, 8 + cost_of(3) + 2);

    // random legal traffic
    b0 = busy_cnt_o; x0 = xfer_cnt_o; w0 = wait_cnt_o;
    eb = 0; ex = 0; ew = 0;
    for (int t = 0; t < 60; t++) begin
      int unsigned waits = $urandom % 4;
      logic [AW-1:0] a = $urandom;
      logic [DW-1:0] d = $urandom;
      idle($urandom % 3);
      if ($urandom % 6 == 0) begin
        int unsigned k = 1 + waits % 3;
        cyc(1, 0, 0, a, 1, d);
        for (int i = 0; i < int'(k); i++) cyc(1, 1, 0, a, 1, d);
        cyc(0, 0, 0, 0, 0, 0);
        eb += 1 + k; ew += k;
      end else begin
        xfer(a, a[0], d, waits);
        check("R9 random cost", last_cost_o, cost_of(waits));
        check("R9 random wait", last_wait_o, waits);
        eb += cost_of(waits); ew += waits; ex++;
      end
    end
    check("R10 random busy", busy_cnt_o - b0, eb);
    check("R10 random wait", wait_cnt_o - w0, ew);
    check("R8 random xfer", xfer_cnt_o - x0, ex);
    check("R13 random no flags", err_flags_o, 0);

    // R3 setup followed by idle
    do_reset();
    cyc(1, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    check("R3 pulse", err_pulse_o, 1);
    check("R3 code", err_code_o, 0);
    check("R3 flag", err_flags_o, 4'b0001);
    idle(3);
    check("R7 sticky", err_flags_o, 4'b0001);
    check("R7 pulse one cycle", err_pulse_o, 0);

    // R4 overlap
    do_reset();
    check("R7 reset clears", err_flags_o, 0);
    cyc(1, 0, 0, 2, 0, 0);
    cyc(1, 1, 0, 2, 0, 0);
    cyc(1, 0, 0, 3, 0, 0);
    check("R4 code", {err_pulse_o, err_code_o}, {1'b1, 2'd1});
    check("R4 flag", err_flags_o, 4'b0010);

    // R5 stability
    do_reset();
    cyc(1, 0, 0, 32'h80, 1, 32'h1);
    cyc(1, 1, 0, 32'h80, 1, 32'h1);
    check("R5 stable ok", err_pulse_o, 0);
    cyc(1, 1, 1, 32'h80, 1, 32'h2);
    check("R5 code", {err_pulse_o, err_code_o}, {1'b1, 2'd2});
    check("R5 flag", err_flags_o, 4'b0100);

    // R6 stray enable alone, then combined with early setup
    do_reset();
    cyc(0, 1, 0, 0, 0, 0);
    check("R6 code", {err_pulse_o, err_code_o}, {1'b1, 2'd3});
    check("R2 stray phase", phase_o, 3);
    check("R6 flag", err_flags_o, 4'b1000);
    do_reset();
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    check("R6 priority code", err_code_o, 0);
    check("R6 both flags", err_flags_o, 4'b1001);

    // R11 saturation on the narrow instance
    do_reset();
    for (int i = 0; i < 17; i++) xfer(i, 0, 0, 0);
    check("R11 wide xfer", xfer_cnt_o, 17);
    check("R11 narrow xfer", s_xfer, sat_of(17, SW));
    check("R11 narrow busy", s_busy, sat_of(34, SW));
    check("R12 wide busy floor", busy_cnt_o, 34);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule